// File: doc/BRIEF.md
# Multi-Image Configuration Reload Sequencer

This controller sits between a configuration PROM that holds several bitstream images and an FPGA loaded in slave-serial mode. The design currently running in the FPGA picks the next image by writing an image index into the controller, then asks for a reboot. The controller drives the FPGA's active-low program line low for a fixed time and waits for the FPGA's init line to rise. It then reads the chosen image from the PROM one byte at a time and shifts each byte out on a data line, one configuration clock per bit.

The image index is the high part of the PROM address, and a byte offset inside the image is the low part. After reset the index register holds zero, so image 0 loads first. Image 0 is the discovery design. It waits for a card, works out which interface the card uses, and reboots into the matching image. When the card is pulled, the controller goes back to image 0 by itself.

A load ends cleanly when the FPGA raises DONE. A load fails if the per-image byte budget runs out first, or if INIT drops while data is being sent. After a failure the controller makes one more attempt, this time with image 0.

PROM reads use two valid/ready channels. On the request channel, the controller holds `prom_req_valid` and `prom_addr` steady until a cycle in which `prom_req_ready` is high. On the response channel, the controller raises `prom_rsp_ready` only while it is waiting for a byte, and it takes `prom_rsp_data` in the cycle where valid and ready are both high. Either side may stall for as many cycles as it needs.

Top module: `cfgload_seq`

## Requirements
- R1: While reset is held and whenever no load is active, `prog_n` is high, `cfg_cclk` is low and `busy` is low. After reset is released, a load of image 0 starts without any request, whatever value is on `ptr_in`.
- R2: Every load begins with `prog_n` low for exactly PROG_CYC clock cycles. No PROM request is issued until `init_n` has been seen high after that pulse.
- R3: Byte n of the load (counting from 0) is read from PROM address `img*IMG_BYTES + n`, i.e. `{img_sel, n}`. Each byte is sent MSB first. `cfg_din` is stable at each rising edge of `cfg_cclk`, and there is exactly one rising edge per bit.
- R4: Once `prom_req_valid` is high without `prom_req_ready`, `prom_req_valid` and `prom_addr` stay unchanged in the next cycle. A response byte is taken only in a cycle where `prom_rsp_ready` is high.
- R5: When DONE rises at the end of a byte, the controller sends no further clock edges. It then drops `busy` and clears `cfg_err`, and `img_sel` shows the image that was loaded.
- R6: If IMG_BYTES bytes are sent without DONE, `cfg_err` goes high and one retry of image 0 follows.
- R7: If `init_n` goes low while a load is streaming, the controller stops sending, sets `cfg_err`, and retries image 0.
- R8: If the retry also fails, the controller goes idle with `cfg_err` still high and does not try again.
- R9: A `ptr_we` pulse while idle stores `ptr_in`. A later `reboot_req` then loads that image.
- R10: A `ptr_we` pulse during a load is ignored, and the stored index keeps its earlier value.
- R11: A `reboot_req` that arrives during a load is held, and that image loads once the current load has finished.
- R12: A falling edge on `card_present` causes a load of image 0, and it is held if a load is running. If a card-removal request and a reboot request are both waiting, image 0 loads first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_in | input | PTR_W | Image index from the running design |
| ptr_we | input | 1 | Stores `ptr_in` while idle |
| reboot_req | input | 1 | Requests a load of the stored image |
| card_present | input | 1 | Card-detect level; a falling edge forces image 0 |
| prom_req_valid | output | 1 | PROM read request valid |
| prom_req_ready | input | 1 | PROM accepts the request |
| prom_addr | output | PTR_W+log2(IMG_BYTES) | PROM byte address {image, offset} |
| prom_rsp_valid | input | 1 | PROM read data valid |
| prom_rsp_ready | output | 1 | Controller ready for read data |
| prom_rsp_data | input | BYTE_W | PROM read data |
| prog_n | output | 1 | Active-low program pulse to the FPGA |
| init_n | input | 1 | FPGA init status; high means ready for data |
| done | input | 1 | FPGA configuration-complete flag |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_din | output | 1 | Configuration serial data |
| busy | output | 1 | A load is in progress |
| cfg_err | output | 1 | The last load attempt failed |
| img_sel | output | PTR_W | Image being loaded or last loaded |

## Verification
The bound checker checks the following on every cycle:
- the length of the program pulse;
- that the PROM port and configuration clock stay quiet while the program pulse is low and while the controller is idle;
- that request address and valid are held under back-pressure;
- that data is stable at each clock rise.

Some behaviours show up only in the bench scenarios, through the exact bytes that arrive at the FPGA model:
- which image is chosen after a pointer write, a queued reboot or a card removal;
- the fallback to image 0 after a budget or INIT failure;
- the single-retry limit;
- that a pointer write made during a load is ignored.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  // Controller phases of a configuration load.
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a load request
    ST_PROG,   // program pulse low
    ST_WINIT,  // waiting for the FPGA to report ready
    ST_CHECK,  // byte boundary: completion / error / budget checks
    ST_FETCH,  // PROM request handshake
    ST_RECV,   // waiting for PROM read data
    ST_SHIFT   // serializing one byte
  } ld_state_e;

endpackage

// File: rtl/cfgload_select.sv
// Holds the image index and the waiting load requests.
module cfgload_select #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ptr_in,
  input  logic             ptr_we,
  input  logic             reboot_req,
  input  logic             card_present,
  input  logic             idle,
  input  logic             take,
  output logic             start,
  output logic [PTR_W-1:0] start_img
);

  logic [PTR_W-1:0] ptr_q;
  logic             disc_pend_q;
  logic             boot_pend_q;
  logic             card_q;
  logic             card_fall;

  assign card_fall = card_q & ~card_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      disc_pend_q <= 1'b1;  // cold start loads the discovery image
      boot_pend_q <= 1'b0;
      card_q      <= 1'b0;
    end else begin
      card_q <= card_present;
      if (ptr_we && idle) begin
        ptr_q <= ptr_in;
      end
      // The discovery request is served before a reboot request.
      if (take) begin
        if (disc_pend_q) disc_pend_q <= 1'b0;
        else             boot_pend_q <= 1'b0;
      end
      if (card_fall)  disc_pend_q <= 1'b1;
      if (reboot_req) boot_pend_q <= 1'b1;
    end
  end

  assign start     = disc_pend_q | boot_pend_q;
  assign start_img = disc_pend_q ? '0 : ptr_q;

endmodule

// File: rtl/cfgload_shift.sv
// Byte serializer: MSB first, two controller clocks per bit (clock low, then high).
module cfgload_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din_byte,
  input  logic              abort,
  output logic              active,
  output logic              cclk,
  output logic              dout
);

  localparam int BCW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sreg_q;
  logic [BCW-1:0]    bitn_q;
  logic              active_q;
  logic              phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q   <= '0;
      bitn_q   <= '0;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
    end else if (abort) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
    end else if (load) begin
      sreg_q   <= din_byte;
      bitn_q   <= '0;
      active_q <= 1'b1;
      phase_q  <= 1'b0;
    end else if (active_q) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        sreg_q  <= {sreg_q[BYTE_W-2:0], 1'b0};
        if (bitn_q == LAST_BIT) active_q <= 1'b0;
        else                    bitn_q   <= bitn_q + 1'b1;
      end
    end
  end

  assign active = active_q;
  assign cclk   = phase_q;
  assign dout   = sreg_q[BYTE_W-1];

endmodule

// File: rtl/cfgload_seq.sv
module cfgload_seq
  import cfgload_pkg::*;
#(
  parameter int PTR_W     = 4,
  parameter int IMG_BYTES = 64,   // bytes per image slot, power of two
  parameter int PROG_CYC  = 8,    // program pulse length in clocks
  parameter int BYTE_W    = 8,
  localparam int OFS_W    = $clog2(IMG_BYTES),
  localparam int ADDR_W   = PTR_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic              ptr_we,
  input  logic              reboot_req,
  input  logic              card_present,
  output logic              prom_req_valid,
  input  logic              prom_req_ready,
  output logic [ADDR_W-1:0] prom_addr,
  input  logic              prom_rsp_valid,
  output logic              prom_rsp_ready,
  input  logic [BYTE_W-1:0] prom_rsp_data,
  output logic              prog_n,
  input  logic              init_n,
  input  logic              done,
  output logic              cfg_cclk,
  output logic              cfg_din,
  output logic              busy,
  output logic              cfg_err,
  output logic [PTR_W-1:0]  img_sel
);

  localparam int CNT_W = OFS_W + 1;
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam logic [CNT_W-1:0] BUDGET   = CNT_W'(IMG_BYTES);
  localparam logic [PCW-1:0]   PROG_END = PCW'(PROG_CYC - 1);

  ld_state_e        st_q;
  logic [PTR_W-1:0] img_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PCW-1:0]   pcnt_q;
  logic             retried_q;
  logic             err_q;

  logic             idle;
  logic             start;
  logic [PTR_W-1:0] start_img;
  logic             sh_active;
  logic             sh_load;
  logic             sh_abort;
  logic             end_ok;
  logic             end_fail;

  assign idle = (st_q == ST_IDLE);

  cfgload_select #(.PTR_W(PTR_W)) u_select (
    .clk          (clk),
    .rst_n        (rst_n),
    .ptr_in       (ptr_in),
    .ptr_we       (ptr_we),
    .reboot_req   (reboot_req),
    .card_present (card_present),
    .idle         (idle),
    .take         (idle & start),
    .start        (start),
    .start_img    (start_img)
  );

  assign sh_load  = (st_q == ST_RECV) && prom_rsp_valid;
  assign sh_abort = (st_q == ST_SHIFT) && (done || !init_n);

  cfgload_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .din_byte (prom_rsp_data),
    .abort    (sh_abort),
    .active   (sh_active),
    .cclk     (cfg_cclk),
    .dout     (cfg_din)
  );

  // End-of-load decisions, taken at byte boundaries or while shifting.
  always_comb begin
    end_ok   = 1'b0;
    end_fail = 1'b0;
    if (st_q == ST_CHECK || st_q == ST_SHIFT) begin
      if (done)         end_ok   = 1'b1;
      else if (!init_n) end_fail = 1'b1;
      else if (st_q == ST_CHECK && cnt_q == BUDGET) end_fail = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      img_q     <= '0;
      cnt_q     <= '0;
      pcnt_q    <= '0;
      retried_q <= 1'b0;
      err_q     <= 1'b0;
    end else if (end_ok) begin
      err_q <= 1'b0;
      st_q  <= ST_IDLE;
    end else if (end_fail) begin
      err_q <= 1'b1;
      if (!retried_q) begin
        retried_q <= 1'b1;
        img_q     <= '0;
        cnt_q     <= '0;
        pcnt_q    <= '0;
        st_q      <= ST_PROG;
      end else begin
        st_q <= ST_IDLE;
      end
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          img_q     <= start_img;
          retried_q <= 1'b0;
          cnt_q     <= '0;
          pcnt_q    <= '0;
          st_q      <= ST_PROG;
        end
        ST_PROG: begin
          if (pcnt_q == PROG_END) st_q   <= ST_WINIT;
          else                    pcnt_q <= pcnt_q + 1'b1;
        end
        ST_WINIT: if (init_n) st_q <= ST_CHECK;
        ST_CHECK: st_q <= ST_FETCH;
        ST_FETCH: if (prom_req_ready) st_q <= ST_RECV;
        ST_RECV:  if (prom_rsp_valid) st_q <= ST_SHIFT;
        ST_SHIFT: if (!sh_active) begin
          cnt_q <= cnt_q + 1'b1;
          st_q  <= ST_CHECK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign prom_req_valid = (st_q == ST_FETCH);
  assign prom_addr      = {img_q, cnt_q[OFS_W-1:0]};
  assign prom_rsp_ready = (st_q == ST_RECV);
  assign prog_n         = (st_q != ST_PROG);
  assign busy           = !idle;
  assign cfg_err        = err_q;
  assign img_sel        = img_q;

endmodule

// File: rtl/cfgload_chk.sv
module cfgload_chk #(
  parameter int PROG_CYC = 8,
  parameter int ADDR_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_n,
  input logic              prom_req_valid,
  input logic              prom_req_ready,
  input logic [ADDR_W-1:0] prom_addr,
  input logic              cfg_cclk,
  input logic              cfg_din,
  input logic              busy
);

  localparam int LCW = $clog2(PROG_CYC + 2) + 1;
  logic [LCW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      low_cnt <= '0;
    else if (prog_n) low_cnt <= '0;
    else if (low_cnt != {LCW{1'b1}}) low_cnt <= low_cnt + 1'b1;
  end

  // R2
  prog_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> (low_cnt == LCW'(PROG_CYC)));

  // R2
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (!prom_req_valid && !cfg_cclk));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prom_req_valid && !prom_req_ready) |=> (prom_req_valid && $stable(prom_addr)));

  // R3
  din_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cclk) |-> $stable(cfg_din));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prog_n && !cfg_cclk && !prom_req_valid));

endmodule

bind cfgload_seq cfgload_chk #(
  .PROG_CYC (PROG_CYC),
  .ADDR_W   (ADDR_W)
) u_cfgload_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .prog_n         (prog_n),
  .prom_req_valid (prom_req_valid),
  .prom_req_ready (prom_req_ready),
  .prom_addr      (prom_addr),
  .cfg_cclk       (cfg_cclk),
  .cfg_din        (cfg_din),
  .busy           (busy)
);

// File: tb/cfgload_seq_test.sv
module cfgload_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int PTR_W      = 4;
  localparam int IMG_BYTES  = 64;
  localparam int PROG_CYC   = 8;
  localparam int ADDR_W     = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PTR_W-1:0] ptr_in = '0;
  logic             ptr_we = 1'b0;
  logic             reboot_req = 1'b0;
  logic             card_present = 1'b1;
  logic             prom_req_valid, prom_req_ready;
  logic [ADDR_W-1:0] prom_addr;
  logic             prom_rsp_valid, prom_rsp_ready;
  logic [7:0]       prom_rsp_data;
  logic             prog_n;
  logic             init_n;
  logic             done = 1'b0;
  logic             cfg_cclk, cfg_din, busy, cfg_err;
  logic [PTR_W-1:0] img_sel;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgload_seq #(.PTR_W(PTR_W), .IMG_BYTES(IMG_BYTES), .PROG_CYC(PROG_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ptr_in(ptr_in), .ptr_we(ptr_we),
    .reboot_req(reboot_req), .card_present(card_present),
    .prom_req_valid(prom_req_valid), .prom_req_ready(prom_req_ready),
    .prom_addr(prom_addr), .prom_rsp_valid(prom_rsp_valid),
    .prom_rsp_ready(prom_rsp_ready), .prom_rsp_data(prom_rsp_data),
    .prog_n(prog_n), .init_n(init_n), .done(done), .cfg_cclk(cfg_cclk),
    .cfg_din(cfg_din), .busy(busy), .cfg_err(cfg_err), .img_sel(img_sel)
  );

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[9:8], 6'b0} ^ 8'h3C;
  endfunction

  // PROM model with back-pressure on both channels
  logic              rsp_pend;
  logic [ADDR_W-1:0] rsp_addr;
  logic [3:0]        rdy_cnt;
  assign prom_req_ready = !rsp_pend && rdy_cnt[0];
  assign prom_rsp_valid = rsp_pend && rdy_cnt[1];
  assign prom_rsp_data  = pat(rsp_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_pend <= 1'b0; rsp_addr <= '0; rdy_cnt <= '0;
    end else begin
      rdy_cnt <= rdy_cnt + 1'b1;
      if (prom_req_valid && prom_req_ready) begin
        rsp_pend <= 1'b1; rsp_addr <= prom_addr;
      end else if (prom_rsp_valid && prom_rsp_ready) begin
        rsp_pend <= 1'b0;
      end
    end
  end

  // FPGA init model
  logic       force_init = 1'b0;
  logic [1:0] icnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_n <= 1'b1; icnt <= '0;
    end else if (!prog_n) begin
      init_n <= 1'b0; icnt <= 2'd3;
    end else if (force_init) begin
      init_n <= 1'b0;
    end else if (icnt != 0) begin
      icnt <= icnt - 1'b1;
    end else begin
      init_n <= 1'b1;
    end
  end

  // Scoreboard queues and plans
  logic [7:0] exp_q[$];
  int plan_done[$];
  int plan_fail[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_img(input int img, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(pat(ADDR_W'(img * IMG_BYTES + i)));
  endtask

  task automatic plan(input int d, input int f);
    plan_done.push_back(d);
    plan_fail.push_back(f);
  endtask

  // Monitor
  int rx = 0, bitn = 0, cur_done = 0, cur_fail = 0;
  int plow = 0, prog_bad = 0, early_bad = 0, hs_bad = 0;
  logic [7:0] sh = '0;
  logic prog_prev = 1'b1, cclk_prev = 1'b0, req_wait_prev = 1'b0;
  logic [ADDR_W-1:0] addr_prev = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prog_prev && !prog_n) begin
        done = 1'b0; force_init = 1'b0; bitn = 0; rx = 0;
        cur_done = (plan_done.size() != 0) ? plan_done.pop_front() : 0;
        cur_fail = (plan_fail.size() != 0) ? plan_fail.pop_front() : 0;
      end
      if (!prog_n) plow++;
      else if (!prog_prev) begin
        if (plow != PROG_CYC) prog_bad++;
        plow = 0;
      end
      if (prom_req_valid && !init_n) early_bad++;
      if (req_wait_prev && !(prom_req_valid && prom_addr == addr_prev)) hs_bad++;
      if (cfg_cclk && !cclk_prev) begin
        sh = {sh[6:0], cfg_din};
        bitn++;
        if (bitn == 8) begin
          bitn = 0;
          rx++;
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected byte", sh, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(sh == e, "R3 byte", sh, e);
          end
          if (cur_done != 0 && rx == cur_done) done = 1'b1;
          if (cur_fail != 0 && rx == cur_fail) force_init = 1'b1;
        end
      end
      req_wait_prev = prom_req_valid && !prom_req_ready;
      addr_prev = prom_addr;
      prog_prev = prog_n;
      cclk_prev = cfg_cclk;
    end
  end

  task automatic wait_idle();
    int quiet = 0;
    repeat (3) @(negedge clk);
    while (quiet < 6) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic write_ptr(input int v);
    @(negedge clk);
    ptr_in = PTR_W'(v); ptr_we = 1'b1;
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic pulse_reboot();
    @(negedge clk);
    reboot_req = 1'b1;
    @(negedge clk);
    reboot_req = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (rx < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    ptr_in = 4'd5;
    plan(10, 0);
    expect_img(0, 10);
    repeat (4) @(negedge clk);
    // R1 reset state
    check(prog_n == 1'b1 && cfg_cclk == 1'b0 && busy == 1'b0, "R1 reset outputs",
          {prog_n, cfg_cclk, busy}, 3'b100);
    rst_n = 1'b1;

    // R1 cold start loads image 0 even though ptr_in is 5; R5 done
    wait_idle();
    check(exp_q.size() == 0, "R1 cold start bytes left", exp_q.size(), 0);
    check(img_sel == 0, "R1 cold image", img_sel, 0);
    check(cfg_err == 1'b0 && rx == 10, "R5 stop at done", rx, 10);

    // R9 pointer write then reboot
    plan(20, 0);
    expect_img(3, 20);
    write_ptr(3);
    pulse_reboot();
    wait_idle();
    check(exp_q.size() == 0, "R9 image 3 bytes left", exp_q.size(), 0);
    check(img_sel == 3, "R9 image select", img_sel, 3);

    // R10 write during load ignored, R11 reboot during load queued
    plan(8, 0); plan(8, 0);
    expect_img(7, 8); expect_img(7, 8);
    write_ptr(7);
    pulse_reboot();
    wait_rx(2);
    write_ptr(2);
    pulse_reboot();
    wait_idle();
    check(exp_q.size() == 0, "R11 queued reload bytes left", exp_q.size(), 0);
    check(img_sel == 7, "R10 pointer unchanged", img_sel, 7);

    // R6 budget exhausted, retry image 0
    plan(0, 0); plan(5, 0);
    expect_img(2, IMG_BYTES); expect_img(0, 5);
    write_ptr(2);
    pulse_reboot();
    while (!(busy && img_sel == 0)) @(negedge clk);
    check(cfg_err == 1'b1, "R6 error flagged on retry", cfg_err, 1);
    wait_idle();
    check(exp_q.size() == 0, "R6 retry bytes left", exp_q.size(), 0);
    check(cfg_err == 1'b0 && img_sel == 0, "R6 retry success", {cfg_err, img_sel}, 0);

    // R8 double failure
    plan(0, 0); plan(0, 0);
    expect_img(4, IMG_BYTES); expect_img(0, IMG_BYTES);
    write_ptr(4);
    pulse_reboot();
    wait_idle();
    check(exp_q.size() == 0, "R8 bytes left", exp_q.size(), 0);
    check(cfg_err == 1'b1 && busy == 1'b0, "R8 stays failed", {cfg_err, busy}, 2);
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R8 no further attempt", busy, 0);

    // R7 INIT drop during streaming
    plan(0, 3); plan(6, 0);
    expect_img(1, 3); expect_img(0, 6);
    write_ptr(1);
    pulse_reboot();
    while (!(busy && img_sel == 0)) @(negedge clk);
    check(cfg_err == 1'b1, "R7 error on init drop", cfg_err, 1);
    wait_idle();
    check(exp_q.size() == 0, "R7 bytes left", exp_q.size(), 0);
    check(cfg_err == 1'b0 && img_sel == 0, "R7 retry image 0", {cfg_err, img_sel}, 0);

    // R12 card removal during load, then while idle
    plan(30, 0); plan(4, 0);
    expect_img(6, 30); expect_img(0, 4);
    write_ptr(6);
    pulse_reboot();
    wait_rx(5);
    card_present = 1'b0;
    wait_idle();
    check(exp_q.size() == 0, "R12 removal during load", exp_q.size(), 0);
    check(img_sel == 0, "R12 back to discovery", img_sel, 0);
    card_present = 1'b1;
    plan(3, 0);
    expect_img(0, 3);
    repeat (3) @(negedge clk);
    card_present = 1'b0;
    wait_idle();
    check(exp_q.size() == 0, "R12 removal while idle", exp_q.size(), 0);

    // Protocol monitors
    check(prog_bad == 0, "R2 program pulse width", prog_bad, 0);
    check(early_bad == 0, "R2 request before init", early_bad, 0);
    check(hs_bad == 0, "R4 request hold", hs_bad, 0);

    summary();
    $finish;
  end

endmodule